// File: doc/BRIEF.md
# BCD Calendar with Buffered User Registers

This block keeps the time of day and the calendar date as binary-coded decimal bytes: seconds, minutes, hours in 24-hour form, a day-of-week number, day of month, month and a two-digit year. A one-cycle pulse on `tick_1hz` moves the count forward by one second. Month lengths and leap years are handled in hardware, so no software correction is needed at the end of a month.

Two copies of the time are held. The running copy advances on every tick, no matter how the control bit is set. The visible copy is what the register port returns. It follows the running copy on every clock while the transfer-enable bit is 1. While that bit is 0 it holds still, so software can read a consistent snapshot without stopping the clock. Writing a time field sets that field in both copies.

Register map (4-bit address): 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 control (bit 0 is transfer enable). Addresses 8 to 15 are unused.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read 00 s, 00 min, 00 h, day-of-week 01, date 01, month 01, year 00, and the control byte reads 01 (transfer enable set).
- R2: Each tick adds one second in BCD. The low digit carries into the high digit after 9. Seconds wrap 59 to 00 and add a minute. Minutes wrap 59 to 00 and add an hour. Hours wrap 23 to 00.
- R3: When the hours wrap, the date advances. It returns to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the other months, and 28 or 29 for month 02.
- R4: February has 29 days when the BCD year is divisible by 4. Year 00 counts as a leap year.
- R5: After the last day of month 12 the month becomes 01 and the year advances, with year 99 wrapping to 00.
- R6: The day of week advances when the hours wrap. It goes from 07 back to 01, and any other value of 07 or more also becomes 01.
- R7: While control bit 0 is 0, the visible fields do not change on ticks, but the running count keeps advancing. The control byte reads bit 0 back.
- R8: On the first clock after control bit 0 returns to 1, the visible fields show the running count, including all ticks that occurred while it was 0.
- R9: A write to addresses 0 to 6 loads that field into both copies at the same clock edge, whatever the transfer-enable setting. The new value can be read right after that edge.
- R10: A write that arrives in the same cycle as a tick stores the written field as given. All other fields advance as the tick dictates.
- R11: An invalid BCD value does not stall the count. A field at or above its upper limit wraps to its lowest value at the next step. A low digit of 9 or more carries into the high digit.
- R12: Addresses 8 to 15 read as 00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1hz | input | 1 | One-cycle pulse that advances the count by one second |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 4 | Register address for both read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data from the visible register at `addr` (combinational) |

## Verification
The bench pushes the carry chain across every kind of boundary:
- A design that compared dates against one fixed month length would turn 30 April into 31 April or end February at the wrong day.
- A leap test on the binary value of the year instead of its decimal value would misjudge years 10 and 12.
- Year 99 must roll to 00, and day of week 7 (or an invalid value) must fold to 1.

The frozen snapshot is checked while ticks keep arriving. A design that stopped the running count, or lost the ticks when transfer was re-enabled, shows a stale time afterwards. A write arriving in the same cycle as a tick is checked on a minute boundary, where a design that dropped either the write or the carry reads back the wrong minute. Invalid seconds and minutes values are loaded to show that the count recovers instead of sticking.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int NF     = 7;
    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0]        bcd_t;
    typedef logic [NF-1:0][BYTE_W-1:0] cal_vec_t;

    typedef enum logic [2:0] {
        F_SEC  = 3'd0,
        F_MIN  = 3'd1,
        F_HOUR = 3'd2,
        F_DOW  = 3'd3,
        F_DATE = 3'd4,
        F_MON  = 3'd5,
        F_YEAR = 3'd6
    } field_e;

    // index 6 (year) first
    localparam cal_vec_t CAL_RESET = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    // one BCD step; a low digit of 9 or more always carries
    function automatic bcd_t bcd_step(input bcd_t v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return v + 8'd1;
    endfunction

    // step with wrap; the limit is a >= compare so bad values cannot stick
    function automatic bcd_t bcd_wrap(input bcd_t v, input bcd_t lim, input bcd_t low);
        if (v >= lim)
            return low;
        else
            return bcd_step(v);
    endfunction

    // 10 is 2 mod 4, so tens*2 + ones has the same remainder as the year
    function automatic logic is_leap(input bcd_t y);
        logic [5:0] s;
        s = {1'b0, y[7:4], 1'b0} + {2'b00, y[3:0]};
        return s[1:0] == 2'b00;
    endfunction

    function automatic bcd_t month_len(input bcd_t m, input bcd_t y);
        case (m)
            8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_next.sv
module cal_next
    import cal_pkg::*;
(
    input  cal_vec_t cur,
    output cal_vec_t nxt
);
    logic sec_end, min_end, hour_end, date_end, mon_end;
    bcd_t last_day;

    always_comb begin
        last_day = month_len(cur[F_MON], cur[F_YEAR]);
        sec_end  = cur[F_SEC] >= 8'h59;
        min_end  = sec_end  && (cur[F_MIN]  >= 8'h59);
        hour_end = min_end  && (cur[F_HOUR] >= 8'h23);
        date_end = hour_end && (cur[F_DATE] >= last_day);
        mon_end  = date_end && (cur[F_MON]  >= 8'h12);

        nxt          = cur;
        nxt[F_SEC]   = bcd_wrap(cur[F_SEC], 8'h59, 8'h00);
        if (sec_end)  nxt[F_MIN]  = bcd_wrap(cur[F_MIN],  8'h59, 8'h00);
        if (min_end)  nxt[F_HOUR] = bcd_wrap(cur[F_HOUR], 8'h23, 8'h00);
        if (hour_end) nxt[F_DOW]  = bcd_wrap(cur[F_DOW],  8'h07, 8'h01);
        if (hour_end) nxt[F_DATE] = bcd_wrap(cur[F_DATE], last_day, 8'h01);
        if (date_end) nxt[F_MON]  = bcd_wrap(cur[F_MON],  8'h12, 8'h01);
        if (mon_end)  nxt[F_YEAR] = bcd_wrap(cur[F_YEAR], 8'h99, 8'h00);
    end
endmodule

// File: rtl/cal_store.sv
module cal_store
    import cal_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  bcd_t              wr_data,
    input  logic              te,
    output cal_vec_t          int_q,
    output cal_vec_t          user_q
);
    cal_vec_t adv;
    cal_vec_t int_d;
    cal_vec_t user_d;

    cal_next u_next (.cur(int_q), .nxt(adv));

    for (genvar i = 0; i < NF; i++) begin : g_field
        logic hit;
        assign hit = wr_en && (wr_addr == ADDR_W'(i));

        always_comb begin
            int_d[i]  = hit ? wr_data : (tick ? adv[i] : int_q[i]);
            user_d[i] = hit ? wr_data : (te ? int_d[i] : user_q[i]);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                int_q[i]  <= CAL_RESET[i];
                user_q[i] <= CAL_RESET[i];
            end else begin
                int_q[i]  <= int_d[i];
                user_q[i] <= user_d[i];
            end
        end
    end
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
    import cal_pkg::*;
#(
    parameter int          ADDR_W    = 4,
    parameter int          CTRL_ADDR = 7,
    parameter int          TE_BIT    = 0,
    parameter logic        TE_RESET  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  bcd_t              wr_data,
    output logic              te
);
    always_ff @(posedge clk) begin
        if (rst)
            te <= TE_RESET;
        else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR))
            te <= wr_data[TE_BIT];
    end
endmodule

// File: rtl/cal_readmux.sv
module cal_readmux
    import cal_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 7,
    parameter int TE_BIT    = 0
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  cal_vec_t          user_q,
    input  logic              te,
    output bcd_t              rd_data
);
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NF; i++) begin
            if (rd_addr == ADDR_W'(i))
                rd_data = user_q[i];
        end
        if (rd_addr == ADDR_W'(CTRL_ADDR))
            rd_data[TE_BIT] = te;
    end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 7,
    parameter int TE_BIT    = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data
);
    cal_vec_t int_q;
    cal_vec_t user_q;
    logic     te_q;

    cal_ctrl #(
        .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .TE_BIT(TE_BIT), .TE_RESET(1'b1)
    ) u_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(addr),
        .wr_data(wr_data), .te(te_q)
    );

    cal_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst(rst), .tick(tick_1hz), .wr_en(wr_en),
        .wr_addr(addr), .wr_data(wr_data), .te(te_q),
        .int_q(int_q), .user_q(user_q)
    );

    cal_readmux #(
        .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .TE_BIT(TE_BIT)
    ) u_rd (
        .rd_addr(addr), .user_q(user_q), .te(te_q), .rd_data(rd_data)
    );
endmodule

// File: rtl/cal_checker.sv
module cal_checker
    import cal_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     tick,
    input logic     wr_en,
    input logic     te,
    input cal_vec_t int_q,
    input cal_vec_t user_q
);
    assert_user_tracks_R8: assert property (@(posedge clk) disable iff (rst)
        te |=> (user_q == int_q));

    assert_user_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (!te && !wr_en) |=> $stable(user_q));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_en) |=> $stable(int_q));

    assert_tick_moves_R11: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en) |=> (int_q != $past(int_q)));

    assert_midnight_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && int_q[F_HOUR] == 8'h23 && int_q[F_MIN] == 8'h59
         && int_q[F_SEC] == 8'h59)
        |=> (int_q[F_HOUR] == 8'h00 && int_q[F_MIN] == 8'h00 && int_q[F_SEC] == 8'h00
             && int_q[F_DOW] >= 8'h01 && int_q[F_DOW] <= 8'h07));
endmodule

bind bcd_calendar cal_checker u_chk (
    .clk(clk), .rst(rst), .tick(tick_1hz), .wr_en(wr_en),
    .te(te_q), .int_q(int_q), .user_q(user_q)
);

// File: tb/test_bcd_calendar.sv
module test_bcd_calendar;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bcd_calendar i_bcd_calendar (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    // {year, month, date, dow, hour, min, sec} before, then after one tick
    localparam int NV = 16;
    localparam logic [111:0] VEC [NV] = '{
        {56'h00_01_01_01_00_00_00, 56'h00_01_01_01_00_00_01},
        {56'h00_01_01_01_00_00_09, 56'h00_01_01_01_00_00_10},
        {56'h21_06_15_03_12_59_59, 56'h21_06_15_03_13_00_00},
        {56'h21_01_31_07_23_59_59, 56'h21_02_01_01_00_00_00},
        {56'h23_02_28_02_23_59_59, 56'h23_03_01_03_00_00_00},
        {56'h24_02_28_02_23_59_59, 56'h24_02_29_03_00_00_00},
        {56'h24_02_29_03_23_59_59, 56'h24_03_01_04_00_00_00},
        {56'h22_04_30_05_23_59_59, 56'h22_05_01_06_00_00_00},
        {56'h22_03_30_05_23_59_59, 56'h22_03_31_06_00_00_00},
        {56'h99_12_31_06_23_59_59, 56'h00_01_01_07_00_00_00},
        {56'h00_02_28_01_23_59_59, 56'h00_02_29_02_00_00_00},
        {56'h10_02_28_01_23_59_59, 56'h10_03_01_02_00_00_00},
        {56'h05_07_04_04_08_10_5C, 56'h05_07_04_04_08_11_00},
        {56'h05_07_04_04_08_3A_59, 56'h05_07_04_04_08_40_00},
        {56'h05_07_04_0B_23_59_59, 56'h05_07_05_01_00_00_00},
        {56'h22_11_30_02_23_59_59, 56'h22_12_01_03_00_00_00}
    };
    localparam logic [23:0] VTAG [NV] = '{
        "R2 ", "R2 ", "R2 ", "R6 ", "R3 ", "R4 ", "R3 ", "R3 ",
        "R3 ", "R5 ", "R4 ", "R4 ", "R11", "R11", "R6 ", "R3 "
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_tick(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1; tick_1hz = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_1hz = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] snap [8];

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'd0, v); check("R1 sec", v, 8'h00);
        rd(4'd1, v); check("R1 min", v, 8'h00);
        rd(4'd2, v); check("R1 hour", v, 8'h00);
        rd(4'd3, v); check("R1 dow", v, 8'h01);
        rd(4'd4, v); check("R1 date", v, 8'h01);
        rd(4'd5, v); check("R1 month", v, 8'h01);
        rd(4'd6, v); check("R1 year", v, 8'h00);
        rd(4'd7, v); check("R1 ctrl", v, 8'h01);

        // vector table
        for (int n = 0; n < NV; n++) begin
            for (int f = 0; f < 7; f++)
                wr(4'(f), VEC[n][56 + f*8 +: 8]);
            pulse_tick();
            for (int f = 0; f < 7; f++) begin
                rd(4'(f), v);
                check($sformatf("%s vector %0d field %0d", VTAG[n], n, f),
                      v, VEC[n][f*8 +: 8]);
            end
        end

        // R12 unmapped addresses
        for (int f = 0; f < 8; f++) rd(4'(f), snap[f]);
        rd(4'd9, v); check("R12 read addr 9", v, 8'h00);
        rd(4'd15, v); check("R12 read addr 15", v, 8'h00);
        wr(4'd12, 8'hFF);
        wr(4'd8, 8'h00);
        for (int f = 0; f < 8; f++) begin
            rd(4'(f), v);
            check($sformatf("R12 field %0d after unmapped write", f), v, snap[f]);
        end

        // R7 freeze, R9 write while frozen, R8 release
        wr(4'd2, 8'h10); wr(4'd1, 8'h20); wr(4'd0, 8'h30);
        wr(4'd7, 8'h00);
        rd(4'd7, v); check("R7 ctrl reads 0", v, 8'h00);
        pulse_tick(); pulse_tick(); pulse_tick();
        rd(4'd0, v); check("R7 sec frozen", v, 8'h30);
        wr(4'd1, 8'h45);
        rd(4'd1, v); check("R9 min written while frozen", v, 8'h45);
        rd(4'd0, v); check("R9 sec still frozen", v, 8'h30);
        wr(4'd7, 8'h01);
        @(negedge clk);
        rd(4'd0, v); check("R8 sec caught up", v, 8'h33);
        rd(4'd1, v); check("R8 min from running copy", v, 8'h45);
        rd(4'd2, v); check("R8 hour", v, 8'h10);
        rd(4'd7, v); check("R7 ctrl reads 1", v, 8'h01);

        // R10 write and tick together
        wr_tick(4'd0, 8'h20);
        rd(4'd0, v); check("R10 sec takes write", v, 8'h20);
        rd(4'd1, v); check("R10 min unchanged", v, 8'h45);
        wr(4'd0, 8'h59);
        wr_tick(4'd0, 8'h10);
        rd(4'd0, v); check("R10 sec takes write at carry", v, 8'h10);
        rd(4'd1, v); check("R10 min carried", v, 8'h46);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule